// File: doc/BRIEF.md
# Programmable Divider and Timer Unit

This block is a small memory-mapped timer peripheral that runs from a 4.194304 MHz system clock. It has four byte-wide registers on a plain register bus. The first is a free-running divider that advances at 16384 Hz. The second is a programmable counter. The third holds a reload value. The fourth is a control register that turns the counter on and picks its step rate.

The divider and the counter step rates all come from one internal prescaler. A two-bit field in the control register selects the counter period from four divisors, and the encoding is not in size order. When the counter steps past 0xFF, it takes the reload value instead of wrapping to zero. In the same cycle, a single-cycle interrupt request pulse goes out for an external interrupt controller to latch.

The register window starts at a base address parameter, which defaults to 0xFF04. Writes take effect at the clock edge and reads are combinational.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the divider, counter and reload registers read 0x00, the control register reads 0xF8, and the interrupt request is low.
- R2: The divider register (offset 0, address 0xFF04) goes up by one every 256 system clocks, counted from the last divider clear. After 0xFF it wraps to 0x00.
- R3: Any bus write to the divider clears it to 0x00 and ignores the write data. The same write also clears the internal prescaler, so the next divider step comes exactly 256 clocks later.
- R4: While control bit 2 is 0, the counter (offset 1, address 0xFF05) keeps its value for any number of clocks.
- R5: While control bit 2 is 1, control bits [1:0] set the counter period in system clocks: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. Counted from a divider clear, the counter's k-th step lands on the edge that is k periods later.
- R6: When the counter steps from 0xFF, it loads the reload register (offset 2, address 0xFF06). At that same edge the interrupt request goes high, and it stays high for exactly one clock.
- R7: The reload and counter registers read back the last value written to them. The control register (offset 3, address 0xFF07) reads back bits [2:0] as written, with bits [7:3] always read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4.194304 MHz in the target |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 16 | Byte address; the four registers sit at BASE_ADDR..BASE_ADDR+3 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (0xFF outside the window) |
| irq_timer | output | 1 | One-cycle overflow interrupt request |

## Verification
The assertions assume that a counter write and a counter overflow both happen at clock edges, with the bus write taking priority, so the one-cycle pulse and reload checks apply only to cycles without a counter write. They also assume that the smallest counter period (16 clocks) is well above one cycle, so two overflows can never come back to back. The stimulus changes inputs only on the falling clock edge. It issues at most one register write per cycle, all inside the four-byte window. Before each timed scenario it clears the divider first, so that every expected step edge is counted from a known prescaler value of zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    OFS_DIV  = 2'd0,
    OFS_CNT  = 2'd1,
    OFS_MOD  = 2'd2,
    OFS_CTRL = 2'd3
  } reg_ofs_e;

  // Number of selectable counter rates and widest tap the selector needs.
  localparam int unsigned N_RATES = 4;
  localparam int unsigned TAP_W   = 10;

  // log2 of the counter period for each rate-select code (non-monotonic order).
  function automatic int unsigned rate_log2(input int unsigned code);
    case (code)
      0:       rate_log2 = 10;
      1:       rate_log2 = 4;
      2:       rate_log2 = 6;
      default: rate_log2 = 8;
    endcase
  endfunction

  typedef struct packed {
    logic       run;
    logic [1:0] rate;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DIV_STEP_LG = 8,
  localparam int unsigned PRE_W      = DIV_W + DIV_STEP_LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [PRE_W-1:0] pre_q,
  output logic [DIV_W-1:0] div_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // The visible divider is the upper slice of the prescaler.
  assign div_q = pre_q[PRE_W-1:DIV_STEP_LG];

endmodule

// File: rtl/tmr_rate_tap.sv
module tmr_rate_tap
  import tmr_pkg::*;
#(
  parameter int unsigned W = TAP_W
) (
  input  logic [W-1:0] pre_lo,
  input  logic         run,
  input  logic [1:0]   rate,
  output logic         tick
);

  logic [N_RATES-1:0] at_end;

  // One detector per selectable period: fires on the last prescaler count
  // of the period, so the counter steps on the following edge.
  for (genvar g = 0; g < N_RATES; g++) begin : g_tap
    localparam int unsigned L = rate_log2(g);
    assign at_end[g] = &pre_lo[L-1:0];
  end

  assign tick = run & at_end[rate];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_mod,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_q,
  output logic             irq
);

  logic at_top;
  logic ovf;

  assign at_top = &cnt_q;
  // A bus write to the counter wins over a step in the same cycle.
  assign ovf    = tick & at_top & ~wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
    end else if (tick) begin
      cnt_q <= at_top ? mod_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
    end else if (wr_mod) begin
      mod_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= ovf;
    end
  end

endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hFF04,
  parameter int unsigned DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [15:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] div_val,
  input  logic [DW-1:0] cnt_val,
  input  logic [DW-1:0] mod_val,
  output logic          wr_div,
  output logic          wr_cnt,
  output logic          wr_mod,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] bus_rdata
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic     hit;
  reg_ofs_e ofs;
  logic     wr_ctrl;

  assign hit = bus_sel & (bus_addr[15:2] == BASE_ADDR[15:2]);
  assign ofs = reg_ofs_e'(bus_addr[1:0]);

  always_comb begin
    wr_div  = 1'b0;
    wr_cnt  = 1'b0;
    wr_mod  = 1'b0;
    wr_ctrl = 1'b0;
    if (hit && bus_wr) begin
      case (ofs)
        OFS_DIV:  wr_div  = 1'b1;
        OFS_CNT:  wr_cnt  = 1'b1;
        OFS_MOD:  wr_mod  = 1'b1;
        default:  wr_ctrl = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    bus_rdata = '1;
    if (hit) begin
      case (ofs)
        OFS_DIV:  bus_rdata = div_val;
        OFS_CNT:  bus_rdata = cnt_val;
        OFS_MOD:  bus_rdata = mod_val;
        default:  bus_rdata = {{(DW-CTRL_W){1'b1}}, ctrl_q};
      endcase
    end
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'hFF04,
  parameter int unsigned DW          = 8,
  parameter int unsigned DIV_STEP_LG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [15:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_timer
);

  localparam int unsigned PRE_W = DW + DIV_STEP_LG;

  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    div_q;
  logic [DW-1:0]    cnt_q;
  logic [DW-1:0]    mod_q;
  logic             wr_div;
  logic             wr_cnt;
  logic             wr_mod;
  ctrl_t            ctrl_q;
  logic             tick;

  tmr_regbus #(.BASE_ADDR(BASE_ADDR), .DW(DW)) u_regbus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .div_val   (div_q),
    .cnt_val   (cnt_q),
    .mod_val   (mod_q),
    .wr_div    (wr_div),
    .wr_cnt    (wr_cnt),
    .wr_mod    (wr_mod),
    .ctrl_q    (ctrl_q),
    .bus_rdata (bus_rdata)
  );

  tmr_prescaler #(.DIV_W(DW), .DIV_STEP_LG(DIV_STEP_LG)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_div),
    .pre_q (pre_q),
    .div_q (div_q)
  );

  tmr_rate_tap #(.W(TAP_W)) u_tap (
    .pre_lo (pre_q[TAP_W-1:0]),
    .run    (ctrl_q.run),
    .rate   (ctrl_q.rate),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(DW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_cnt (wr_cnt),
    .wr_mod (wr_mod),
    .wdata  (bus_wdata),
    .cnt_q  (cnt_q),
    .mod_q  (mod_q),
    .irq    (irq_timer)
  );

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    ofs,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_timer,
  input logic          run,
  input logic          wr_div,
  input logic          wr_cnt,
  input logic [DW-1:0] div_q,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] mod_q
);

  // R6: request lasts exactly one clock
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |=> !irq_timer);

  // R6: when the request rises the counter holds the reload value
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |-> (cnt_q == $past(mod_q)));

  // R4: disabled counter does not move unless the bus writes it
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));

  // R3: a divider write leaves the divider at zero
  a_r3_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (div_q == '0));

  // R2: without a clear, the divider stays or advances by one
  a_r2_div_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> ((div_q == $past(div_q)) || (div_q == $past(div_q) + 1'b1)));

  // R7: unused control bits always read as one
  a_r7_ctrl_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ofs == 2'd3) |-> (bus_rdata[DW-1:3] == '1));

endmodule

bind tmr_unit tmr_unit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel && (bus_addr[15:2] == BASE_ADDR[15:2])),
  .bus_wr    (bus_wr),
  .ofs       (bus_addr[1:0]),
  .bus_rdata (bus_rdata),
  .irq_timer (irq_timer),
  .run       (ctrl_q.run),
  .wr_div    (wr_div),
  .wr_cnt    (wr_cnt),
  .div_q     (div_q),
  .cnt_q     (cnt_q),
  .mod_q     (mod_q)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;

  localparam logic [15:0] A_DIV  = 16'hFF04;
  localparam logic [15:0] A_CNT  = 16'hFF05;
  localparam logic [15:0] A_MOD  = 16'hFF06;
  localparam logic [15:0] A_CTRL = 16'hFF07;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq_timer;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_timer (irq_timer)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_DIV, v);  check("R1 div", v, 8'h00);
    rd(A_CNT, v);  check("R1 cnt", v, 8'h00);
    rd(A_MOD, v);  check("R1 mod", v, 8'h00);
    rd(A_CTRL, v); check("R1 ctrl", v, 8'hF8);
    check("R1 irq", {7'd0, irq_timer}, 8'h00);
  endtask

  task automatic t_divider();
    logic [7:0] v;
    wr(A_DIV, 8'hAB);               // edge E0
    rd(A_DIV, v);  check("R3 data ignored", v, 8'h00);
    edges(255);    rd(A_DIV, v); check("R2 before step", v, 8'h00);
    edges(1);      rd(A_DIV, v); check("R2 first step", v, 8'h01);
    edges(65279);  rd(A_DIV, v); check("R2 top", v, 8'hFF);
    edges(1);      rd(A_DIV, v); check("R2 wrap", v, 8'h00);
    edges(100);
    wr(A_DIV, 8'h00);               // prescaler cleared mid-period
    edges(255);    rd(A_DIV, v); check("R3 prescaler clear", v, 8'h00);
    edges(1);      rd(A_DIV, v); check("R3 step after clear", v, 8'h01);
  endtask

  task automatic t_rate(input logic [1:0] sel, input int period);
    logic [7:0] v;
    wr(A_DIV, 8'h00);               // E0
    wr(A_CNT, 8'h20);               // E1
    wr(A_CTRL, {5'd0, 1'b1, sel});  // E2
    edges(period - 3); rd(A_CNT, v); check("R5 before period", v, 8'h20);
    edges(1);          rd(A_CNT, v); check("R5 one period", v, 8'h21);
    edges(period);     rd(A_CNT, v); check("R5 two periods", v, 8'h22);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(A_DIV, 8'h00);               // E0
    wr(A_MOD, 8'hF0);               // E1
    wr(A_CNT, 8'hFE);               // E2
    wr(A_CTRL, 8'h05);              // E3
    edges(13); rd(A_CNT, v); check("R6 at top", v, 8'hFF);
    check("R6 no irq yet", {7'd0, irq_timer}, 8'h00);
    edges(15); check("R6 irq before ovf", {7'd0, irq_timer}, 8'h00);
    edges(1);  rd(A_CNT, v); check("R6 reload", v, 8'hF0);
    check("R6 irq high", {7'd0, irq_timer}, 8'h01);
    edges(1);  check("R6 irq one cycle", {7'd0, irq_timer}, 8'h00);
    rd(A_CNT, v); check("R6 after reload", v, 8'hF0);
    rd(A_MOD, v); check("R7 mod readback", v, 8'hF0);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    wr(A_CTRL, 8'h01);
    wr(A_CNT, 8'h10);
    edges(2000);
    rd(A_CNT, v); check("R4 held", v, 8'h10);
    check("R4 no irq", {7'd0, irq_timer}, 8'h00);
  endtask

  task automatic t_ctrl_read();
    logic [7:0] v;
    wr(A_CTRL, 8'h02); rd(A_CTRL, v); check("R7 ctrl 02", v, 8'hFA);
    wr(A_CTRL, 8'h3D); rd(A_CTRL, v); check("R7 ctrl 3D", v, 8'hFD);
    wr(A_CNT, 8'h5A);  rd(A_CNT, v);  check("R7 cnt readback", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_rate(2'b00, 1024);
    t_rate(2'b01, 16);
    t_rate(2'b10, 64);
    t_rate(2'b11, 256);
    t_overflow();
    t_hold();
    t_ctrl_read();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule